// File: doc/BRIEF.md
# BT.656 Byte-Stream Splitter with Clipping and Chroma Upsampling

This block takes an 8-bit multiplexed component video byte stream, one byte per clock at 27 MHz, and turns it into parallel luma and chroma samples at the 13.5 MS/s luma rate. It finds the four-byte timing reference codes in the stream. The start-of-active-video code opens a line of 720 luma samples. Each luma sample leaves the block together with a Cb/Cr pair on a single-cycle strobe.

Active samples are limited to their legal ranges. Chroma arrives at half the luma rate, so every odd luma sample is given the rounded mean of the chroma pairs on either side of it. Lines whose start code marks vertical blanking still produce 720 strobes, but those samples are forced to black and neutral chroma. A selectable line length (525-line or 625-line timing) sets a watchdog that raises a flag when the start codes stop arriving.

Top module: `bt656_splitter`

## Requirements
- R1: A timing reference is the byte run FF, 00, 00, XY. Only an XY byte with bit 4 clear (start of active video) opens a line. An XY byte with bit 4 set (end of active video) does not open a line and does not restart one.
- R2: The 1440 bytes that follow the opening XY byte are read as Cb, Y, Cr, Y repeating. Each line yields exactly 720 strobes on `pix_vld`, in luma order, and two strobes are never on adjacent cycles.
- R3: On lines marked active, each output luma equals the input Y byte limited to the range 16..235.
- R4: On lines marked active, every Cb and Cr byte is limited to the range 16..240 before it is used.
- R5: Even luma sample 2k (k from 0) is output with chroma pair k unchanged.
- R6: Odd luma sample 2k+1 is output with (C[k] + C[k+1] + 1) >> 1 for each of Cb and Cr. Sample 719 repeats pair 359.
- R7: When bit 5 of the opening XY byte is set, the line's 720 samples are output with Y = 16, Cb = Cr = 128 and `act_o` low, whatever the data bytes hold. When that bit is clear, `act_o` is high.
- R8: `fld_o` and `vblk_o` carry bits 6 and 5 of the XY byte that opened the line each sample belongs to.
- R9: The line length L is 1716 clocks when `std_sel` = 0 and 1728 when `std_sel` = 1. `sync_lost` rises once L clocks have passed since the last opening XY byte with no new one. Opening codes exactly L clocks apart never raise it. It stays high until the next opening code.
- R10: The next opening XY byte clears `sync_lost`.
- R11: After reset, `pix_vld`, `act_o`, `fld_o`, `vblk_o` and `sync_lost` are 0, `y_o` is 16, and `cb_o` and `cr_o` are 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz byte clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Multiplexed byte stream, one byte per clock |
| std_sel | input | 1 | Line timing select: 0 = 1716 clocks, 1 = 1728 clocks |
| pix_vld | output | 1 | One-cycle strobe per luma sample |
| y_o | output | 8 | Luma sample |
| cb_o | output | 8 | Blue-difference chroma, offset 128 |
| cr_o | output | 8 | Red-difference chroma, offset 128 |
| act_o | output | 1 | Sample belongs to an active (non-vertical-blanking) line |
| fld_o | output | 1 | Field bit of the line |
| vblk_o | output | 1 | Vertical blanking bit of the line |
| sync_lost | output | 1 | No start code seen within one line length |

## Verification
The assertions check the following on every cycle:
- the strobe never fires on two cycles in a row;
- active samples stay inside their legal luma and chroma ranges;
- an opening code always restarts the line position;
- the loss flag stays high until a start code arrives, and is cleared by one.

The exact values can only be shown by the bench's scenarios. These are the interpolated chroma and its rounding direction, the repeat of the last pair, the black fill on vertically blanked lines and the per-line sample count. The same holds for the loss flag's exact boundary, where codes at precisely one line length must never raise it under either line-length setting.

// File: rtl/vdmx_pkg.sv
package vdmx_pkg;
  localparam int PW = 8;

  localparam logic [PW-1:0] Y_LO  = 8'd16;
  localparam logic [PW-1:0] Y_HI  = 8'd235;
  localparam logic [PW-1:0] C_LO  = 8'd16;
  localparam logic [PW-1:0] C_HI  = 8'd240;
  localparam logic [PW-1:0] Y_BLK = 8'd16;
  localparam logic [PW-1:0] C_MID = 8'd128;

  typedef struct packed {
    logic [PW-1:0] y;
    logic [PW-1:0] cb;
    logic [PW-1:0] cr;
  } pix_t;

  function automatic logic [PW-1:0] clamp(input logic [PW-1:0] x,
                                          input logic [PW-1:0] lo,
                                          input logic [PW-1:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic logic [PW-1:0] avg2(input logic [PW-1:0] a,
                                         input logic [PW-1:0] b);
    logic [PW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{PW{1'b0}}, 1'b1};
    return s[PW:1];
  endfunction
endpackage

// File: rtl/vdmx_trs_detect.sv
module vdmx_trs_detect (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [vdmx_pkg::PW-1:0] din,
  output logic                    sav,
  output logic                    xy_f,
  output logic                    xy_v
);
  logic [vdmx_pkg::PW-1:0] h0, h1, h2;
  logic                    hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      h0 <= '0;
      h1 <= '0;
      h2 <= '0;
    end else begin
      h2 <= h1;
      h1 <= h0;
      h0 <= din;
    end
  end

  assign hit  = (h2 == '1) && (h1 == '0) && (h0 == '0);
  assign sav  = hit && !din[4];
  assign xy_f = din[6];
  assign xy_v = din[5];

  // R1
  sav_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    sav |-> ($past(din, 3) == 8'hFF && $past(din, 2) == 8'h00 && $past(din) == 8'h00));
endmodule

// File: rtl/vdmx_line_timer.sv
module vdmx_line_timer #(
  parameter int ACT_PIX = 720,
  parameter int LEN_A   = 1716,
  parameter int LEN_B   = 1728,
  parameter int POS_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sav,
  input  logic             std_sel,
  input  logic             xy_f,
  input  logic             xy_v,
  output logic             in_line,
  output logic [POS_W-1:0] pos,
  output logic             line_f,
  output logic             line_v,
  output logic             sync_lost
);
  localparam int LAST_POS = 2 * ACT_PIX + 3;
  localparam int LEN_MAX  = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int CNT_W    = $clog2(LEN_MAX);
  localparam logic [POS_W-1:0] POS_END = POS_W'(LAST_POS);
  localparam logic [CNT_W-1:0] LIM_A   = CNT_W'(LEN_A - 1);
  localparam logic [CNT_W-1:0] LIM_B   = CNT_W'(LEN_B - 1);

  logic [CNT_W-1:0] gap_cnt;
  logic [CNT_W-1:0] gap_lim;

  assign gap_lim = std_sel ? LIM_B : LIM_A;

  // line position: byte index inside the active window plus a 4-byte tail
  always_ff @(posedge clk) begin
    if (rst) begin
      in_line <= 1'b0;
      pos     <= '0;
      line_f  <= 1'b0;
      line_v  <= 1'b0;
    end else if (sav) begin
      in_line <= 1'b1;
      pos     <= '0;
      line_f  <= xy_f;
      line_v  <= xy_v;
    end else if (in_line) begin
      if (pos == POS_END) in_line <= 1'b0;
      else                pos     <= pos + 1'b1;
    end
  end

  // start-code watchdog
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt   <= '0;
      sync_lost <= 1'b0;
    end else if (sav) begin
      gap_cnt   <= '0;
      sync_lost <= 1'b0;
    end else if (gap_cnt >= gap_lim) begin
      sync_lost <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R1
  line_start_chk: assert property (@(posedge clk) disable iff (rst)
    sav |=> (in_line && pos == '0));
  // R9
  lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && !sav) |=> sync_lost);
  // R10
  lost_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sav |=> !sync_lost);
endmodule

// File: rtl/vdmx_pair_interp.sv
module vdmx_pair_interp #(
  parameter int ACT_PIX = 720,
  parameter int POS_W   = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_line,
  input  logic [POS_W-1:0]        pos,
  input  logic [vdmx_pkg::PW-1:0] y_in,
  input  logic [vdmx_pkg::PW-1:0] c_in,
  input  logic                    line_f,
  input  logic                    line_v,
  output logic                    pix_vld_o,
  output logic [vdmx_pkg::PW-1:0] y_o,
  output logic [vdmx_pkg::PW-1:0] cb_o,
  output logic [vdmx_pkg::PW-1:0] cr_o,
  output logic                    act_o,
  output logic                    f_o,
  output logic                    v_o
);
  import vdmx_pkg::*;

  localparam logic [POS_W-1:0] VIRT_START = POS_W'(2 * ACT_PIX);
  localparam logic [POS_W-1:0] FIRST_EMIT = POS_W'(4);

  logic [1:0]    phase;
  logic          virt, early, emit;
  logic [PW-1:0] cb_n, cr_n, y_e_n;   // pair being received
  logic [PW-1:0] cb_p, cr_p, y_e, y_od; // completed previous pair
  pix_t          ep;

  assign phase = pos[1:0];
  assign virt  = (pos >= VIRT_START);
  assign early = (pos < FIRST_EMIT);

  // even sample leaves on a Cb slot, odd sample on a Cr slot, one pair late
  always_comb begin
    emit  = 1'b0;
    ep.y  = y_e;
    ep.cb = cb_p;
    ep.cr = cr_p;
    if (in_line && !early) begin
      if (phase == 2'd0) begin
        emit = 1'b1;
      end else if (phase == 2'd2) begin
        emit = 1'b1;
        ep.y = y_od;
        if (!virt) begin
          ep.cb = avg2(cb_p, cb_n);
          ep.cr = avg2(cr_p, c_in);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cb_n  <= C_MID;
      cr_n  <= C_MID;
      y_e_n <= Y_BLK;
      cb_p  <= C_MID;
      cr_p  <= C_MID;
      y_e   <= Y_BLK;
      y_od  <= Y_BLK;
    end else if (in_line && !virt) begin
      case (phase)
        2'd0: cb_n  <= c_in;
        2'd1: y_e_n <= y_in;
        2'd2: cr_n  <= c_in;
        default: begin
          cb_p <= cb_n;
          cr_p <= cr_n;
          y_e  <= y_e_n;
          y_od <= y_in;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_vld_o <= 1'b0;
      y_o       <= Y_BLK;
      cb_o      <= C_MID;
      cr_o      <= C_MID;
      act_o     <= 1'b0;
      f_o       <= 1'b0;
      v_o       <= 1'b0;
    end else begin
      pix_vld_o <= emit;
      if (emit) begin
        act_o <= !line_v;
        f_o   <= line_f;
        v_o   <= line_v;
        y_o   <= line_v ? Y_BLK : ep.y;
        cb_o  <= line_v ? C_MID : ep.cb;
        cr_o  <= line_v ? C_MID : ep.cr;
      end
    end
  end

  // R2
  strobe_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld_o |-> $past(in_line));
endmodule

// File: rtl/bt656_splitter.sv
module bt656_splitter #(
  parameter int ACT_PIX = 720,
  parameter int LEN_A   = 1716,
  parameter int LEN_B   = 1728
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [vdmx_pkg::PW-1:0] din,
  input  logic                    std_sel,
  output logic                    pix_vld,
  output logic [vdmx_pkg::PW-1:0] y_o,
  output logic [vdmx_pkg::PW-1:0] cb_o,
  output logic [vdmx_pkg::PW-1:0] cr_o,
  output logic                    act_o,
  output logic                    fld_o,
  output logic                    vblk_o,
  output logic                    sync_lost
);
  localparam int LAST_POS = 2 * ACT_PIX + 3;
  localparam int POS_W    = $clog2(LAST_POS + 1);

  logic                    sav, xy_f, xy_v;
  logic                    in_line, line_f, line_v;
  logic [POS_W-1:0]        pos;
  logic [vdmx_pkg::PW-1:0] y_clip, c_clip;

  assign y_clip = vdmx_pkg::clamp(din, vdmx_pkg::Y_LO, vdmx_pkg::Y_HI);
  assign c_clip = vdmx_pkg::clamp(din, vdmx_pkg::C_LO, vdmx_pkg::C_HI);

  vdmx_trs_detect u_trs (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .sav  (sav),
    .xy_f (xy_f),
    .xy_v (xy_v)
  );

  vdmx_line_timer #(
    .ACT_PIX (ACT_PIX),
    .LEN_A   (LEN_A),
    .LEN_B   (LEN_B),
    .POS_W   (POS_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .sav       (sav),
    .std_sel   (std_sel),
    .xy_f      (xy_f),
    .xy_v      (xy_v),
    .in_line   (in_line),
    .pos       (pos),
    .line_f    (line_f),
    .line_v    (line_v),
    .sync_lost (sync_lost)
  );

  vdmx_pair_interp #(
    .ACT_PIX (ACT_PIX),
    .POS_W   (POS_W)
  ) u_interp (
    .clk       (clk),
    .rst       (rst),
    .in_line   (in_line),
    .pos       (pos),
    .y_in      (y_clip),
    .c_in      (c_clip),
    .line_f    (line_f),
    .line_v    (line_v),
    .pix_vld_o (pix_vld),
    .y_o       (y_o),
    .cb_o      (cb_o),
    .cr_o      (cr_o),
    .act_o     (act_o),
    .f_o       (fld_o),
    .v_o       (vblk_o)
  );

  // R2
  pix_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld |=> !pix_vld);
  // R3
  y_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && act_o) |-> (y_o >= 8'd16 && y_o <= 8'd235));
  // R4
  c_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && act_o) |-> (cb_o >= 8'd16 && cb_o <= 8'd240 && cr_o >= 8'd16 && cr_o <= 8'd240));
  // R8
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    pix_vld |-> (act_o == !vblk_o));
endmodule

// File: tb/bt656_splitter_tb_top.sv
`timescale 1ns/1ps
module bt656_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX  = 720;
  localparam int NPAIR = 360;
  localparam int NBYTE = 1440;
  localparam int LEN_A = 1716;
  localparam int LEN_B = 1728;
  localparam logic [7:0] CLIPV [14] = '{8'd0, 8'd5, 8'd15, 8'd16, 8'd17, 8'd128, 8'd234,
                                        8'd235, 8'd236, 8'd239, 8'd240, 8'd241, 8'd250, 8'd255};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h10;
  logic       std_sel = 1'b0;
  logic       pix_vld, act_o, fld_o, vblk_o, sync_lost;
  logic [7:0] y_o, cb_o, cr_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bt656_splitter dut_i (
    .clk(clk), .rst(rst), .din(din), .std_sel(std_sel),
    .pix_vld(pix_vld), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o),
    .act_o(act_o), .fld_o(fld_o), .vblk_o(vblk_o), .sync_lost(sync_lost)
  );

  typedef struct {
    logic [7:0] y, cb, cr;
    logic       act, f, v;
    int         kind;   // 0 even, 1 odd, 2 blanked
    bit         clipline;
  } exp_t;

  exp_t expq[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   prev_vld = 1'b0;
  bit   lost_seen = 1'b0;

  function automatic logic [7:0] cy(input logic [7:0] x);
    return (x < 8'd16) ? 8'd16 : (x > 8'd235) ? 8'd235 : x;
  endfunction
  function automatic logic [7:0] cc(input logic [7:0] x);
    return (x < 8'd16) ? 8'd16 : (x > 8'd240) ? 8'd240 : x;
  endfunction
  function automatic logic [7:0] mean2(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = (int'(a) + int'(b) + 1) / 2;
    return 8'(s);
  endfunction
  function automatic logic [7:0] xy_byte(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    din = b;
  endtask

  // output monitor against the expected-sample queue
  always @(negedge clk) begin
    if (!rst) begin
      if (sync_lost) lost_seen = 1'b1;
      if (prev_vld && pix_vld) check(1'b0, "R2", "strobe on adjacent cycles", 1, 0);
      prev_vld = pix_vld;
      if (pix_vld) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2", "extra sample", 1, 0);
        end else begin
          string tag;
          mon_e = expq.pop_front();
          if (mon_e.kind == 2)      tag = "R7 blanked sample";
          else if (mon_e.kind == 0) tag = mon_e.clipline ? "R3 R4 R5 even sample" : "R5 even sample";
          else                      tag = mon_e.clipline ? "R3 R4 R6 odd sample" : "R6 odd sample";
          check({y_o, cb_o, cr_o} == {mon_e.y, mon_e.cb, mon_e.cr}, tag, "y/cb/cr",
                int'({y_o, cb_o, cr_o}), int'({mon_e.y, mon_e.cb, mon_e.cr}));
          check({act_o, fld_o, vblk_o} == {mon_e.act, mon_e.f, mon_e.v}, "R8", "act/f/v flags",
                int'({act_o, fld_o, vblk_o}), int'({mon_e.act, mon_e.f, mon_e.v}));
        end
      end
    end
  end

  // mode 0 random, 1 directed clip values, 2 rounding pattern
  task automatic send_line(input int len, input bit f, input bit v, input int mode,
                           input bit chk_clear);
    logic [7:0] d [NBYTE];
    logic [7:0] yv [NPIX];
    logic [7:0] cbk [NPAIR];
    logic [7:0] crk [NPAIR];
    for (int i = 0; i < NBYTE; i++) begin
      if (mode == 1)      d[i] = CLIPV[i % 14];
      else if (mode == 2) begin
        case (i % 4)
          0:       d[i] = ((i / 4) % 2 == 1) ? 8'd20 : 8'd23;
          2:       d[i] = ((i / 4) % 2 == 1) ? 8'd200 : 8'd201;
          default: d[i] = 8'(i / 2);
        endcase
      end else d[i] = 8'($urandom_range(254, 1));
    end
    for (int k = 0; k < NPAIR; k++) begin
      cbk[k]        = cc(d[4 * k]);
      yv[2 * k]     = cy(d[4 * k + 1]);
      crk[k]        = cc(d[4 * k + 2]);
      yv[2 * k + 1] = cy(d[4 * k + 3]);
    end
    for (int j = 0; j < NPIX; j++) begin
      exp_t e;
      int k;
      k = j / 2;
      e.f = f;
      e.v = v;
      e.act = !v;
      e.clipline = (mode == 1);
      if (v) begin
        e.kind = 2; e.y = 8'd16; e.cb = 8'd128; e.cr = 8'd128;
      end else if (j % 2 == 0 || k == NPAIR - 1) begin
        e.kind = j % 2; e.y = yv[j]; e.cb = cbk[k]; e.cr = crk[k];
      end else begin
        e.kind = 1; e.y = yv[j];
        e.cb = mean2(cbk[k], cbk[k + 1]);
        e.cr = mean2(crk[k], crk[k + 1]);
      end
      expq.push_back(e);
    end
    put(8'hFF); put(8'h00); put(8'h00); put(xy_byte(f, v, 1'b0));
    for (int i = 0; i < NBYTE; i++) begin
      put(d[i]);
      if (chk_clear && i == 2)
        check(sync_lost == 1'b0, "R10", "loss flag after start code", sync_lost, 0);
    end
    put(8'hFF); put(8'h00); put(8'h00); put(xy_byte(f, v, 1'b1));
    for (int i = 0; i < len - NBYTE - 8; i++) put((i % 2 == 0) ? 8'h80 : 8'h10);
    check(expq.size() == 0, "R1 R2", "samples left after line", expq.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5161));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset values
    check(pix_vld == 1'b0, "R11", "pix_vld after reset", pix_vld, 0);
    check({y_o, cb_o, cr_o} == {8'd16, 8'd128, 8'd128}, "R11", "samples after reset",
          int'({y_o, cb_o, cr_o}), int'({8'd16, 8'd128, 8'd128}));
    check({act_o, fld_o, vblk_o, sync_lost} == 4'b0, "R11", "flags after reset",
          int'({act_o, fld_o, vblk_o, sync_lost}), 0);

    std_sel = 1'b0;
    send_line(LEN_A, 1'b0, 1'b0, 0, 1'b0);
    lost_seen = 1'b0;
    send_line(LEN_A, 1'b0, 1'b0, 1, 1'b0);
    send_line(LEN_A, 1'b1, 1'b0, 0, 1'b0);
    send_line(LEN_A, 1'b0, 1'b1, 0, 1'b0);
    send_line(LEN_A, 1'b1, 1'b0, 2, 1'b0);
    send_line(LEN_A, 1'b0, 1'b0, 0, 1'b0);
    // R9 exact 1716 spacing never flags
    check(lost_seen == 1'b0, "R9", "loss seen at exact line length", lost_seen, 0);

    std_sel = 1'b1;
    lost_seen = 1'b0;
    send_line(LEN_B, 1'b0, 1'b0, 0, 1'b0);
    send_line(LEN_B, 1'b1, 1'b0, 0, 1'b0);
    check(lost_seen == 1'b0, "R9", "loss seen at exact 1728 spacing", lost_seen, 0);

    std_sel = 1'b0;
    send_line(LEN_B, 1'b0, 1'b0, 0, 1'b0);
    check(sync_lost == 1'b1, "R9", "1728-clock line under 1716 timing", sync_lost, 1);
    send_line(LEN_A, 1'b0, 1'b0, 0, 1'b1);

    for (int i = 0; i < 2000; i++) put(8'h10);
    check(sync_lost == 1'b1, "R9", "loss flag after idle gap", sync_lost, 1);
    send_line(LEN_A, 1'b1, 1'b1, 0, 1'b1);
    send_line(LEN_A, 1'b1, 1'b0, 1, 1'b0);
    check(sync_lost == 1'b0, "R10", "loss flag stays clear", sync_lost, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule